// File: doc/BRIEF.md
# PWM Compare Shadow-Load Unit

This block is the counter-compare stage of a pulse-width modulator. It has a time-base counter and two compare channels, A and B. The counter can count up, count down, count up-down, or stop. Each channel keeps two registers. The first is a shadow register that software writes. The second is an active register that the comparator uses. A channel can take new compare values at once (bypass). It can also buffer them in the shadow register until a chosen counter event, or a rising edge on an external sync input, copies them across. This keeps a compare value from changing in the middle of a PWM period.

All configuration arrives through a single-cycle register write strobe. A full flag for each channel shows that a value has been written but not yet transferred. A one-cycle match output for each channel marks the counter reaching the active compare value. One interrupt line can be set to fire on counter zero, on counter period, or on both. Nothing records which of the two events caused it.

Top module: `pwm_cmp_shadow`

## Requirements
- R1: After reset, both active values, both full flags, the counter, the interrupt select and the period are 0. The counter is stopped (count mode 11). Both channels have shadowing enabled, load mode 00 and sync select off.
- R2: Register addresses are: 0 = compare A, 1 = compare B, 2 = control, 3 = period, 4 = count mode (bits 1:0). While a channel's bypass bit is 0, a write to its compare address goes to the shadow register only. The active value does not change, and the full flag is 1 from the next cycle until a transfer happens.
- R3: Control bit 0 is the bypass bit for A and bit 4 is the bypass bit for B. When a channel's bypass bit is 1, a compare write appears on the active value in the next cycle and sets that channel's full flag to 0.
- R4: Control bits 2:1 set A's load mode and bits 6:5 set B's. The codes are 00 = load on counter zero, 01 = load on counter period, 10 = load on either, 11 = never load. A load copies shadow to active at the clock edge that ends the cycle in which the counter shows the event, and clears the full flag.
- R5: If a compare write and a load happen on the same edge, the active register takes the old shadow value. The new value stays in the shadow register and the full flag stays 1.
- R6: Control bit 3 is the sync select for A and bit 7 is the sync select for B. When a channel's sync select is set, a rising edge on sync_in loads that channel, even in load mode 11. Holding sync_in high does not cause further loads.
- R7: The count mode codes are 00 = up (0..period, then back to 0), 01 = down (period..0, then back to period), 10 = up-down (turns back at period and at 0), and 11 = stopped (the value is held).
- R8: Control bits 9:8 select the interrupt. 00 = never, 01 = zero, 10 = period, 11 = both. irq is high in any cycle in which the running counter shows a selected event, and is never high while the counter is stopped.
- R9: cmp_match[0] (A) and cmp_match[1] (B) are high in a cycle in which the running counter equals that channel's active value.
- R10: A write to, or a load of, one channel does not change the other channel's active value or full flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| sync_in | input | 1 | External sync-load request, rising edge active |
| cnt_value | output | CNT_W | Time-base counter value |
| cmp_act_a | output | CNT_W | Active compare value of channel A |
| cmp_act_b | output | CNT_W | Active compare value of channel B |
| shadow_full | output | 2 | Pending-write flags, bit 0 = A, bit 1 = B |
| cmp_match | output | 2 | Compare match, bit 0 = A, bit 1 = B |
| irq | output | 1 | Zero/period interrupt |

## Verification
Some faults in this block stay hidden for a whole PWM period. A wrongly held shadow value, or a missed load, only shows on cmp_act_a/b and shadow_full at the next matching zero or period edge. A wrong load event therefore shows up at most one counter period after the write that set it up. The same-cycle write-and-load case only shows up at the port when the full flag is still 1 and the active value is the older shadow. For that reason the write is driven exactly on the cycle where the counter shows zero. A mistake in the counter direction shows on cnt_value within one cycle of a turning point. An event-decode fault shows on irq in that same cycle.

// File: rtl/pwm_cmp_pkg.sv
`timescale 1ns/1ps
package pwm_cmp_pkg;

  typedef enum logic [1:0] {
    CNT_UP     = 2'b00,
    CNT_DOWN   = 2'b01,
    CNT_UPDOWN = 2'b10,
    CNT_STOP   = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    LD_ZERO   = 2'b00,
    LD_PRD    = 2'b01,
    LD_EITHER = 2'b10,
    LD_FREEZE = 2'b11
  } ld_mode_e;

  // per-channel control nibble: {sync_sel, ld_mode, bypass}
  typedef struct packed {
    logic     sync_sel;
    ld_mode_e ld_mode;
    logic     bypass;
  } chan_cfg_t;

  localparam int unsigned CHAN_N   = 2;
  localparam int unsigned CFG_W    = $bits(chan_cfg_t);
  localparam int unsigned CTRL_W   = CHAN_N * CFG_W + 2;

  localparam logic [2:0] ADDR_CMP_A = 3'd0;
  localparam logic [2:0] ADDR_CMP_B = 3'd1;
  localparam logic [2:0] ADDR_CTRL  = 3'd2;
  localparam logic [2:0] ADDR_PRD   = 3'd3;
  localparam logic [2:0] ADDR_MODE  = 3'd4;

  function automatic logic ld_hit(input ld_mode_e m, input logic z, input logic p);
    case (m)
      LD_ZERO:   return z;
      LD_PRD:    return p;
      LD_EITHER: return z | p;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic irq_hit(input logic [1:0] sel, input logic z, input logic p);
    return (sel[0] & z) | (sel[1] & p);
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
  import pwm_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             zero_evt,
  output logic             prd_evt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic dir_up;

  // returns {next direction, next count}
  function automatic logic [CNT_W:0] advance(input cnt_mode_e m, input logic d,
                                             input logic [CNT_W-1:0] c,
                                             input logic [CNT_W-1:0] p);
    logic             nd;
    logic [CNT_W-1:0] nc;
    nd = d;
    nc = c;
    case (m)
      CNT_UP: begin
        nd = 1'b1;
        nc = (c >= p) ? '0 : c + ONE;
      end
      CNT_DOWN: begin
        nd = 1'b1;
        nc = (c == '0 || c > p) ? p : c - ONE;
      end
      CNT_UPDOWN: begin
        if (d) begin
          if (c >= p) begin
            nd = 1'b0;
            nc = (p == '0) ? '0 : c - ONE;
          end else begin
            nc = c + ONE;
          end
        end else begin
          if (c == '0) begin
            nd = 1'b1;
            nc = (p == '0) ? '0 : ONE;
          end else begin
            nc = c - ONE;
          end
        end
      end
      default: ;
    endcase
    return {nd, nc};
  endfunction

  assign running  = (mode != CNT_STOP);
  assign zero_evt = running && (cnt == '0);
  assign prd_evt  = running && (cnt == prd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else begin
      {dir_up, cnt} <= advance(mode, dir_up, cnt, prd);
    end
  end

  // R7: a running counter within the period stays within it
  assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt <= prd) |=> (cnt <= $past(prd)));

  // R7: up-down mode turns back at the period
  assert_updown_turn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CNT_UPDOWN && dir_up && cnt == prd && prd != '0)
      |=> (cnt == $past(cnt) - ONE));

  // R7: stopped counter holds its value
  assert_stop_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running) |=> $stable(cnt));

endmodule

// File: rtl/pwm_cmp_channel.sv
`timescale 1ns/1ps
module pwm_cmp_channel
  import pwm_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chan_cfg_t        cfg,
  input  logic             wr_hit,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             zero_evt,
  input  logic             prd_evt,
  input  logic             running,
  input  logic             sync_rise,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] active,
  output logic             full,
  output logic             match
);

  logic [CNT_W-1:0] shadow;
  logic             load_evt;

  assign load_evt = ld_hit(cfg.ld_mode, zero_evt, prd_evt) | (cfg.sync_sel & sync_rise);
  assign match    = running && (cnt == active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
      full   <= 1'b0;
    end else if (cfg.bypass) begin
      if (wr_hit) begin
        shadow <= wr_val;
        active <= wr_val;
        full   <= 1'b0;
      end
    end else begin
      if (load_evt) begin
        active <= shadow;
        full   <= 1'b0;
      end
      if (wr_hit) begin
        shadow <= wr_val;
        full   <= 1'b1;
      end
    end
  end

  // R2: active value only moves on a load or a direct write
  assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(load_evt && !cfg.bypass) && !(wr_hit && cfg.bypass)) |=> $stable(active));

  // R2: a buffered write raises the full flag
  assert_write_sets_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !cfg.bypass) |=> full);

  // R3: direct write lands on the active value and leaves full low
  assert_bypass_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && cfg.bypass) |=> (!full && active == $past(wr_val)));

  // R4: a load without a competing write empties the shadow
  assert_load_clears_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !wr_hit && !cfg.bypass) |=> !full);

  // R5: same-edge write and load moves the older shadow value
  assert_merge_keeps_new_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && wr_hit && !cfg.bypass) |=> (full && active == $past(shadow)));

endmodule

// File: rtl/pwm_cmp_shadow.sv
`timescale 1ns/1ps
module pwm_cmp_shadow
  import pwm_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             sync_in,
  output logic [CNT_W-1:0] cnt_value,
  output logic [CNT_W-1:0] cmp_act_a,
  output logic [CNT_W-1:0] cmp_act_b,
  output logic [1:0]       shadow_full,
  output logic [1:0]       cmp_match,
  output logic             irq
);

  localparam int unsigned IRQ_LSB = CHAN_N * CFG_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  prd_q;
  cnt_mode_e         mode_q;
  logic              sync_q;
  logic              sync_rise;
  logic              running;
  logic              zero_evt;
  logic              prd_evt;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        irq_sel;
  logic [CNT_W-1:0]  act   [CHAN_N];
  logic [CHAN_N-1:0] full;
  logic [CHAN_N-1:0] match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      prd_q  <= '0;
      mode_q <= CNT_STOP;
      sync_q <= 1'b0;
    end else begin
      sync_q <= sync_in;
      if (wr_en) begin
        case (wr_addr)
          ADDR_CTRL: ctrl_q <= wr_data[CTRL_W-1:0];
          ADDR_PRD:  prd_q  <= wr_data;
          ADDR_MODE: mode_q <= cnt_mode_e'(wr_data[1:0]);
          default: ;
        endcase
      end
    end
  end

  assign sync_rise = sync_in & ~sync_q;
  assign irq_sel   = ctrl_q[IRQ_LSB +: 2];

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .prd      (prd_q),
    .cnt      (cnt),
    .running  (running),
    .zero_evt (zero_evt),
    .prd_evt  (prd_evt)
  );

  for (genvar ch = 0; ch < CHAN_N; ch++) begin : g_chan
    logic wr_hit;
    assign wr_hit = wr_en && (wr_addr == ADDR_CMP_A + 3'(ch));

    pwm_cmp_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (chan_cfg_t'(ctrl_q[ch*CFG_W +: CFG_W])),
      .wr_hit    (wr_hit),
      .wr_val    (wr_data),
      .zero_evt  (zero_evt),
      .prd_evt   (prd_evt),
      .running   (running),
      .sync_rise (sync_rise),
      .cnt       (cnt),
      .active    (act[ch]),
      .full      (full[ch]),
      .match     (match[ch])
    );
  end

  assign cnt_value   = cnt;
  assign cmp_act_a   = act[0];
  assign cmp_act_b   = act[1];
  assign shadow_full = full;
  assign cmp_match   = match;
  assign irq         = irq_hit(irq_sel, zero_evt, prd_evt);

  // R8: the interrupt needs a counter event behind it
  assert_irq_has_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (zero_evt || prd_evt));

  // R8: no interrupt from a stopped counter
  assert_irq_quiet_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CNT_STOP) |-> !irq);

  // R9: a match never comes from a stopped counter
  assert_match_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CNT_STOP) |-> (cmp_match == 2'b00));

  // R10: writing channel A leaves channel B untouched
  assert_chan_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_CMP_A && !(sync_rise && ctrl_q[7]) && !zero_evt && !prd_evt)
      |=> ($stable(cmp_act_b) && $stable(shadow_full[1])));

endmodule

// File: tb/test_pwm_cmp_shadow.sv
`timescale 1ns/1ps
module test_pwm_cmp_shadow;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             sync_in = 1'b0;
  logic [CNT_W-1:0] cnt_value, cmp_act_a, cmp_act_b;
  logic [1:0]       shadow_full, cmp_match;
  logic             irq;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwm_cmp_shadow #(.CNT_W(CNT_W)) i_pwm_cmp_shadow (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .sync_in,
    .cnt_value, .cmp_act_a, .cmp_act_b, .shadow_full, .cmp_match, .irq
  );

  typedef struct packed {
    logic [2:0]  addr;
    logic [15:0] data;
    logic [15:0] exp_a;
    logic [15:0] exp_b;
    logic [1:0]  exp_full;
  } vec_t;

  // stopped counter: no load events, pure register behaviour (R2, R3, R10)
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'h0010, 16'h0000, 16'h0000, 2'b01},
    '{3'd1, 16'h0020, 16'h0000, 16'h0000, 2'b11},
    '{3'd0, 16'h0011, 16'h0000, 16'h0000, 2'b11},
    '{3'd2, 16'h0001, 16'h0000, 16'h0000, 2'b11},
    '{3'd0, 16'h0005, 16'h0005, 16'h0000, 2'b10},
    '{3'd2, 16'h0000, 16'h0005, 16'h0000, 2'b10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    for (int k = 0; k < 50 && cnt_value != v; k++) step();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 act_a", cmp_act_a, 0);
    chk("R1 act_b", cmp_act_b, 0);
    chk("R1 full", shadow_full, 0);
    chk("R1 cnt", cnt_value, 0);
    chk("R1 irq", irq, 0);
    chk("R1 match", cmp_match, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].addr, VECS[i].data);
      chk("R2/R3/R10 act_a", cmp_act_a, VECS[i].exp_a);
      chk("R2/R3/R10 act_b", cmp_act_b, VECS[i].exp_b);
      chk("R2/R3/R10 full", shadow_full, VECS[i].exp_full);
    end

    // load on zero (A) and period (B), irq on zero
    wr(3'd3, 16'd4);
    wr(3'd2, 16'h0120);
    wr(3'd0, 16'd3);
    wr(3'd1, 16'd2);
    chk("R8 irq stopped", irq, 0);
    chk("R2 full both", shadow_full, 2'b11);
    wr(3'd4, 16'd0);                 // up count
    chk("R8 irq zero", irq, 1);
    chk("R4 act_a before", cmp_act_a, 5);
    step();
    chk("R4 act_a zero load", cmp_act_a, 3);
    chk("R4 full after A load", shadow_full, 2'b10);
    chk("R7 up count", cnt_value, 1);
    step(); step();
    chk("R9 match A", cmp_match, 2'b01);
    step();
    chk("R8 irq off at period", irq, 0);
    chk("R4 act_b waits", cmp_act_b, 0);
    step();
    chk("R7 up wrap", cnt_value, 0);
    chk("R4 act_b period load", cmp_act_b, 2);
    chk("R4 full empty", shadow_full, 2'b00);

    // R5 same-edge write and load
    wait_cnt(2);
    wr(3'd0, 16'd6);
    wait_cnt(0);
    wr(3'd0, 16'd9);
    chk("R5 active takes old shadow", cmp_act_a, 6);
    chk("R5 full stays", shadow_full[0], 1);
    wait_cnt(0);
    step();
    chk("R5 new value later", cmp_act_a, 9);

    // R4 freeze, R6 sync load
    wr(3'd2, 16'h0126);
    wr(3'd0, 16'd10);
    wait_cnt(0); step();
    wait_cnt(0); step();
    chk("R4 freeze holds", cmp_act_a, 9);
    chk("R4 freeze full", shadow_full[0], 1);
    wr(3'd2, 16'h012E);
    sync_in = 1'b1;
    step();
    chk("R6 sync load", cmp_act_a, 10);
    chk("R6 sync clears full", shadow_full[0], 0);
    wr(3'd0, 16'd11);
    repeat (6) step();
    chk("R6 level no reload", cmp_act_a, 10);
    chk("R6 full pending", shadow_full[0], 1);
    sync_in = 1'b0;
    step();
    sync_in = 1'b1;
    step();
    chk("R6 second edge", cmp_act_a, 11);
    sync_in = 1'b0;

    // up-down, load on either, irq on period
    wait_cnt(1);
    wr(3'd4, 16'd2);
    chk("R7 mode switch", cnt_value, 2);
    wr(3'd2, 16'h0240);
    wr(3'd1, 16'd1);
    chk("R7 updown reach prd", cnt_value, 4);
    chk("R8 irq period", irq, 1);
    chk("R4 either waits", cmp_act_b, 2);
    step();
    chk("R7 updown turn", cnt_value, 3);
    chk("R4 either load", cmp_act_b, 1);
    step(); step();
    chk("R9 match B", cmp_match, 2'b10);
    step();
    chk("R8 irq not zero", irq, 0);
    step();
    chk("R7 updown bottom", cnt_value, 1);
    wr(3'd4, 16'd1);                 // down
    step(); step(); step();
    chk("R7 down wrap", cnt_value, 4);

    // stop and bypass on B
    wr(3'd4, 16'd3);
    repeat (3) step();
    chk("R7 stop holds", cnt_value, 3);
    chk("R8 irq stopped", irq, 0);
    wr(3'd2, 16'h0010);
    wr(3'd1, 16'd7);
    chk("R3 B direct", cmp_act_b, 7);
    chk("R3 B full low", shadow_full[1], 0);
    chk("R10 A untouched", cmp_act_a, 11);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule